// File: doc/BRIEF.md
# Slave Parallel Configuration Port

This block is the slave end of a synchronous parallel bus driven by an external master. Each rising clock edge with the chip select high is one access, and a two-bit type code gives its kind: an address beat, a debug read beat, a debug write beat or a configuration beat. The bus is 16 bits wide or runs in a narrow 8-bit mode set by a static strap. Wide values are sent as several beats, low part first. These values are a 32-bit register address, with the row in bits [31:16] and the register in bits [15:0], and 96-bit register data.

Debug writes put a whole 96-bit word together and hand it to the register file behind the port in a single-cycle strobe. Debug reads return the register file's word one slice per beat and raise a read-valid flag. A latency strap can move the read data one cycle later than that flag. Configuration beats are filtered by device identity. The first configuration beat after each address carries an 8-bit bitstream ID. The later beats are forwarded downstream only when that ID equals the zero-extended 4-bit chip ID or is the broadcast value 0xFF. A read, write or configuration beat that arrives without a complete address sets a sticky error flag and has no other effect.

Top module: `spc_port`

## Requirements
- R1: A beat is taken only on a rising edge with `cs_i` high. With `cs_i` low, no output and no internal state changes.
- R2: An address is sent low beat first. It takes 4 beats in narrow mode (`wide_i`=0, bits [7:0] per beat) and 2 beats in wide mode (bits [15:0] per beat). `reg_addr_o` shows the full 32-bit value after the last beat.
- R3: A debug write word is sent low beat first, in 12 narrow or 6 wide beats. `reg_wr_o` is high for exactly the one cycle after the last beat, with the full word on `reg_wdata_o`.
- R4: Each debug read beat k returns slice k of `reg_rdata_i` (bits [8k+7:8k] narrow, [16k+15:16k] wide). `data_oe_o` is high exactly in the cycle after the beat.
- R5: With `lat_i`=0 the slice is on `rd_data_o` in the same cycle as `data_oe_o`. With `lat_i`=1 it appears one cycle later.
- R6: In narrow mode `data_i[15:8]` is ignored. The upper byte of `rd_data_o` and of `cfg_data_o` is zero.
- R7: A read, write or configuration beat before any address has completed sets `err_o`. `err_o` stays set until reset, and the beat causes no strobe, no read-valid and no forwarding.
- R8: The first configuration beat after each completed address is a header with the bitstream ID in `data_i[7:0]`. The header is never forwarded.
- R9: When the header ID equals {4'b0, `chip_id_i`}, each later configuration beat shows up on `cfg_data_o` with `cfg_valid_o` high in the next cycle.
- R10: A header ID of 0xFF forwards the later configuration beats whatever the chip ID is.
- R11: Any other header ID causes the later configuration beats to be dropped. `cfg_valid_o` stays low for them.
- R12: The type code is 00 for address, 01 for debug read, 10 for debug write and 11 for configuration.
- R13: A completed address restarts the data beat count and re-arms the header, so a partly sent word is thrown away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wide_i | input | 1 | Static strap: 1 selects the 16-bit bus, 0 the 8-bit bus |
| lat_i | input | 1 | Static strap: 1 adds a cycle of read-data latency |
| chip_id_i | input | 4 | Device identity of this chip |
| cs_i | input | 1 | Chip select, active high |
| type_i | input | 2 | Access type code |
| data_i | input | 16 | Write data bus |
| reg_rdata_i | input | 96 | Word of the addressed register |
| reg_addr_o | output | 32 | Assembled register address |
| reg_wdata_o | output | 96 | Assembled write word |
| reg_wr_o | output | 1 | One-cycle register write strobe |
| data_oe_o | output | 1 | Read data valid flag |
| rd_data_o | output | 16 | Read data slice |
| cfg_valid_o | output | 1 | Forwarded configuration word is valid |
| cfg_data_o | output | 16 | Forwarded configuration word |
| err_o | output | 1 | Sticky sequence error |

## Verification
The bench runs the full address, write and read sequences once for every combination of bus width and latency strap. Each beat carries a distinct byte pattern, so a swapped, repeated or misplaced slice changes the result, and narrow-mode beats put junk on the upper lines to expose lanes that are not masked. The identity filter is tried against all sixteen chip IDs with four header classes: exact match, broadcast, a low-nibble mismatch and a high-nibble mismatch. These separate a correct compare from one that ignores the upper nibble or the broadcast value. Separate runs cover beats with the chip select low, data beats before any address, and a new address that cuts off a partly sent word.

// File: rtl/spc_pkg.sv
package spc_pkg;
  typedef enum logic [1:0] {
    ACC_ADDR = 2'b00,
    ACC_RD   = 2'b01,
    ACC_WR   = 2'b10,
    ACC_CFG  = 2'b11
  } acc_e;
endpackage

// File: rtl/spc_beat_cnt.sv
module spc_beat_cnt #(
  parameter int MAX_BEATS = 12,
  localparam int CW = $clog2(MAX_BEATS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wide_i,
  input  logic          step_i,
  input  logic          clr_i,
  output logic [CW-1:0] idx_o,
  output logic          last_o
);
  localparam logic [CW-1:0] LAST_N = CW'(MAX_BEATS - 1);
  localparam logic [CW-1:0] LAST_W = CW'(MAX_BEATS / 2 - 1);

  assign last_o = (idx_o == (wide_i ? LAST_W : LAST_N));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_o <= '0;
    else if (clr_i)  idx_o <= '0;
    else if (step_i) idx_o <= last_o ? '0 : idx_o + 1'b1;
  end

  AST_IDX_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(idx_o) < MAX_BEATS); // R2
endmodule

// File: rtl/spc_word_asm.sv
module spc_word_asm #(
  parameter int FULL_W = 96,
  parameter int LANE_W = 8,
  localparam int NB = FULL_W / LANE_W,
  localparam int CW = $clog2(NB)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              wide_i,
  input  logic [CW-1:0]     idx_i,
  input  logic [2*LANE_W-1:0] din_i,
  output logic [FULL_W-1:0] word_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) word_o <= '0;
    else if (we_i) begin
      for (int b = 0; b < NB; b++) begin
        if (!wide_i && b == int'(idx_i))
          word_o[b*LANE_W +: LANE_W] <= din_i[LANE_W-1:0];
        else if (wide_i && (b / 2) == int'(idx_i))
          word_o[b*LANE_W +: LANE_W] <= din_i[(b % 2)*LANE_W +: LANE_W];
      end
    end
  end
endmodule

// File: rtl/spc_id_filter.sv
module spc_id_filter #(
  parameter int DATA_W = 16,
  parameter int ID_W   = 4,
  localparam int LANE_W = DATA_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              beat_i,
  input  logic [ID_W-1:0]   chip_id_i,
  input  logic [DATA_W-1:0] din_i,
  output logic              cfg_valid_o,
  output logic [DATA_W-1:0] cfg_data_o
);
  localparam logic [LANE_W-1:0] BCAST = '1;

  logic              hdr_pend, match;
  logic [LANE_W-1:0] cid_ext, hid;

  assign cid_ext = {{(LANE_W-ID_W){1'b0}}, chip_id_i};
  assign hid     = din_i[LANE_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hdr_pend    <= 1'b0;
      match       <= 1'b0;
      cfg_valid_o <= 1'b0;
      cfg_data_o  <= '0;
    end else begin
      cfg_valid_o <= 1'b0;
      if (arm_i) begin
        hdr_pend <= 1'b1;
        match    <= 1'b0;
      end else if (beat_i && hdr_pend) begin
        hdr_pend <= 1'b0;
        match    <= (hid == BCAST) || (hid == cid_ext);
      end else if (beat_i && match) begin
        cfg_valid_o <= 1'b1;
        cfg_data_o  <= din_i;
      end
    end
  end

  AST_HDR_NOT_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(beat_i && hdr_pend) |-> !cfg_valid_o); // R8
  AST_FWD_ONLY_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_o |-> match); // R11
endmodule

// File: rtl/spc_rd_pipe.sv
module spc_rd_pipe #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lat_i,
  input  logic              launch_i,
  input  logic [DATA_W-1:0] slice_i,
  output logic              data_oe_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] s1_data, s2_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_oe_o <= 1'b0;
      s1_data   <= '0;
      s2_data   <= '0;
    end else begin
      data_oe_o <= launch_i;
      if (launch_i) s1_data <= slice_i;
      s2_data <= s1_data;
    end
  end

  assign rd_data_o = lat_i ? s2_data : s1_data;

  AST_OE_PULSE_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(launch_i) |-> data_oe_o); // R4
endmodule

// File: rtl/spc_port.sv
module spc_port
  import spc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 32,
  parameter int REG_W  = 96,
  parameter int ID_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wide_i,
  input  logic              lat_i,
  input  logic [ID_W-1:0]   chip_id_i,
  input  logic              cs_i,
  input  logic [1:0]        type_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [REG_W-1:0]  reg_rdata_i,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [REG_W-1:0]  reg_wdata_o,
  output logic              reg_wr_o,
  output logic              data_oe_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              cfg_valid_o,
  output logic [DATA_W-1:0] cfg_data_o,
  output logic              err_o
);
  localparam int LANE_W  = DATA_W / 2;
  localparam int A_BEATS = ADDR_W / LANE_W;
  localparam int D_BEATS = REG_W / LANE_W;
  localparam int ACW     = $clog2(A_BEATS);
  localparam int DCW     = $clog2(D_BEATS);

  acc_e              acc;
  logic [DATA_W-1:0] din;
  logic              addr_vld;
  logic              addr_beat, addr_done, seq_bad;
  logic              rd_beat, wr_beat, cfg_beat;
  logic [ACW-1:0]    a_idx;
  logic [DCW-1:0]    d_idx;
  logic              a_last, d_last;
  logic [DATA_W-1:0] rd_slice;

  assign acc = acc_e'(type_i);
  assign din = wide_i ? data_i : {{LANE_W{1'b0}}, data_i[LANE_W-1:0]};

  assign addr_beat = cs_i && (acc == ACC_ADDR);
  assign addr_done = addr_beat && a_last;
  assign seq_bad   = cs_i && (acc != ACC_ADDR) && !addr_vld;
  assign rd_beat   = cs_i && addr_vld && (acc == ACC_RD);
  assign wr_beat   = cs_i && addr_vld && (acc == ACC_WR);
  assign cfg_beat  = cs_i && addr_vld && (acc == ACC_CFG);

  spc_beat_cnt #(.MAX_BEATS(A_BEATS)) u_acnt (
    .clk_i, .rst_ni, .wide_i, .step_i(addr_beat), .clr_i(1'b0),
    .idx_o(a_idx), .last_o(a_last));

  spc_beat_cnt #(.MAX_BEATS(D_BEATS)) u_dcnt (
    .clk_i, .rst_ni, .wide_i, .step_i(rd_beat || wr_beat), .clr_i(addr_done),
    .idx_o(d_idx), .last_o(d_last));

  spc_word_asm #(.FULL_W(ADDR_W), .LANE_W(LANE_W)) u_aasm (
    .clk_i, .rst_ni, .we_i(addr_beat), .wide_i, .idx_i(a_idx),
    .din_i(din), .word_o(reg_addr_o));

  spc_word_asm #(.FULL_W(REG_W), .LANE_W(LANE_W)) u_wasm (
    .clk_i, .rst_ni, .we_i(wr_beat), .wide_i, .idx_i(d_idx),
    .din_i(din), .word_o(reg_wdata_o));

  always_comb begin
    if (wide_i) rd_slice = reg_rdata_i[d_idx*DATA_W +: DATA_W];
    else        rd_slice = {{LANE_W{1'b0}}, reg_rdata_i[d_idx*LANE_W +: LANE_W]};
  end

  spc_rd_pipe #(.DATA_W(DATA_W)) u_rd (
    .clk_i, .rst_ni, .lat_i, .launch_i(rd_beat), .slice_i(rd_slice),
    .data_oe_o, .rd_data_o);

  spc_id_filter #(.DATA_W(DATA_W), .ID_W(ID_W)) u_idf (
    .clk_i, .rst_ni, .arm_i(addr_done), .beat_i(cfg_beat), .chip_id_i,
    .din_i(din), .cfg_valid_o, .cfg_data_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_vld <= 1'b0;
      reg_wr_o <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      if (addr_beat) addr_vld <= a_last;
      reg_wr_o <= wr_beat && d_last;
      if (seq_bad) err_o <= 1'b1;
    end
  end

  AST_WR_NEEDS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |-> $past(cs_i)); // R1
  AST_WR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |=> !reg_wr_o); // R3
  AST_OE_FROM_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> $past(cs_i && type_i == 2'b01)); // R4
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R7
  AST_NO_WR_UNADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(seq_bad) |-> !reg_wr_o && !data_oe_o && !cfg_valid_o); // R7
endmodule

// File: tb/spc_port_tb.sv
module spc_port_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wide_i = 1'b0, lat_i = 1'b0;
  logic [3:0]  chip_id_i = '0;
  logic        cs_i = 1'b0;
  logic [1:0]  type_i = '0;
  logic [15:0] data_i = '0;
  logic [95:0] reg_rdata_i = '0;
  logic [31:0] reg_addr_o;
  logic [95:0] reg_wdata_o;
  logic        reg_wr_o, data_oe_o, cfg_valid_o, err_o;
  logic [15:0] rd_data_o, cfg_data_o;

  int  n_chk = 0, n_bad = 0;
  bit  done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  spc_port dut_i (.*);

  task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic beat(input logic cs, input logic [1:0] t, input logic [15:0] d);
    @(negedge clk_i);
    cs_i = cs; type_i = t; data_i = d;
    @(posedge clk_i);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; cs_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  function automatic logic [15:0] lane(input logic [95:0] v, input int k);
    if (wide_i) return v[16*k +: 16];
    return {8'hC3, v[8*k +: 8]};
  endfunction

  function automatic logic [15:0] exp_slice(input logic [95:0] v, input int k);
    if (wide_i) return v[16*k +: 16];
    return {8'h00, v[8*k +: 8]};
  endfunction

  task automatic send_addr(input logic [31:0] a);
    int n = wide_i ? 2 : 4;
    for (int k = 0; k < n; k++) beat(1'b1, 2'b00, lane({64'h0, a}, k));
  endtask

  task automatic send_wr(input logic [95:0] v, input string req);
    int n = wide_i ? 6 : 12;
    for (int k = 0; k < n; k++) begin
      beat(1'b1, 2'b10, lane(v, k));
      if (k == 0) chk({req, " no strobe mid-word"}, 96'(reg_wr_o), 96'(0));
    end
    chk({req, " strobe"}, 96'(reg_wr_o), 96'(1));
    chk({req, " word"}, reg_wdata_o, v);
    beat(1'b0, 2'b10, 16'hFFFF);
    chk({req, " strobe drops"}, 96'(reg_wr_o), 96'(0));
  endtask

  initial begin
    logic [31:0] a;
    logic [95:0] w, r;
    do_reset();
    chk("R1 reset wr", 96'(reg_wr_o), 96'(0));
    chk("R1 reset oe", 96'(data_oe_o), 96'(0));
    chk("R1 reset cfg", 96'(cfg_valid_o), 96'(0));
    chk("R7 reset err", 96'(err_o), 96'(0));
    // R7: data beats before any address
    beat(1'b1, 2'b10, 16'h1111);
    chk("R7 err set", 96'(err_o), 96'(1));
    chk("R7 no strobe", 96'(reg_wr_o), 96'(0));
    beat(1'b1, 2'b01, 16'h2222);
    chk("R7 no oe", 96'(data_oe_o), 96'(0));
    beat(1'b1, 2'b11, 16'h33FF);
    chk("R7 no cfg", 96'(cfg_valid_o), 96'(0));
    beat(1'b0, 2'b00, 16'h0);
    chk("R7 sticky", 96'(err_o), 96'(1));

    for (int pass = 0; pass < 4; pass++) begin
      wide_i = pass[1]; lat_i = pass[0];
      do_reset();
      // R1: cs low is ignored
      beat(1'b0, 2'b00, 16'hABCD);
      beat(1'b0, 2'b10, 16'hABCD);
      chk("R1 cs low addr", 96'(reg_addr_o), 96'(0));
      chk("R1 cs low err", 96'(err_o), 96'(0));
      a = {16'hFF00 | 16'(pass), 16'h0A0B + 16'(pass * 7)};
      send_addr(a);
      chk("R2 R12 address", 96'(reg_addr_o), 96'(a));
      w = {32'hDEADBEEF, 32'h01234567, 32'h89ABCDEF} ^ {3{32'(pass * 32'h1010101)}};
      send_wr(w, "R3");
      // R13: partial write then new address restarts the count
      beat(1'b1, 2'b10, 16'h5A5A);
      beat(1'b1, 2'b10, 16'hA5A5);
      send_addr(a ^ 32'h00010001);
      chk("R13 new address", 96'(reg_addr_o), 96'(a ^ 32'h00010001));
      send_wr(~w, "R13");
      // R4 R5 R6: reads
      r = {32'h0F1E2D3C, 32'h4B5A6978, 32'h8796A5B4} + 96'(pass);
      reg_rdata_i = r;
      for (int k = 0; k < (wide_i ? 6 : 12); k++) begin
        beat(1'b1, 2'b01, 16'hFFFF);
        chk("R4 oe", 96'(data_oe_o), 96'(1));
        if (!lat_i) chk("R4 R6 data", 96'(rd_data_o), 96'(exp_slice(r, k)));
        beat(1'b0, 2'b01, 16'h0);
        chk("R4 oe drop", 96'(data_oe_o), 96'(0));
        if (lat_i) chk("R5 late data", 96'(rd_data_o), 96'(exp_slice(r, k)));
      end
      // R8..R11: identity filter sweep
      for (int c = 0; c < 16; c++) begin
        chip_id_i = 4'(c);
        for (int v = 0; v < 4; v++) begin
          logic [7:0]  bid;
          logic [15:0] word;
          bit          fwd;
          bid = (v == 0) ? {4'h0, 4'(c)} : (v == 1) ? 8'hFF :
                (v == 2) ? {4'h0, 4'(c) ^ 4'h1} : {4'h1, 4'(c)};
          fwd = (v < 2);
          word = 16'h9100 + 16'(c * 4 + v);
          send_addr(a);
          beat(1'b1, 2'b11, {8'h3C, bid});
          chk("R8 header held", 96'(cfg_valid_o), 96'(0));
          beat(1'b1, 2'b11, word);
          if (v == 0) chk("R9 match fwd", 96'(cfg_valid_o), 96'(1));
          else if (v == 1) chk("R10 bcast fwd", 96'(cfg_valid_o), 96'(1));
          else chk("R11 mismatch drop", 96'(cfg_valid_o), 96'(0));
          if (fwd) chk("R6 R9 cfg data", 96'(cfg_data_o),
                       96'(wide_i ? word : {8'h00, word[7:0]}));
        end
      end
      chk("R7 no spurious err", 96'(err_o), 96'(0));
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule